// File: doc/BRIEF.md
# Trimmed Real-Time-Clock Prescaler

This block sits between a 512 Hz tick source and the hundredths-of-a-second counter of a real-time clock. Each 512 Hz tick arrives as a one-cycle enable in the system clock domain. The block emits a one-cycle 100 Hz tick for the hundredths counter and a one-cycle 1 Hz tick that marks the end of every second. It also emits a registered copy of the raw 512 Hz enable that software can use to measure the crystal.

Rate correction is digital. A 6-bit trim word holds a sign and a magnitude N. A fixed number of input ticks is normally spread over the 100 output ticks of a second. During a corrected second that number becomes one fewer (the clock speeds up) or one more (it slows down). Only the first N seconds of a repeating cycle are corrected. The cycle is shorter for speeding up than for slowing down. The block keeps its own seconds index inside that cycle. It takes a new trim word only when a second ends, so no second ever mixes two divisors.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While `rst` is high, `tick100`, `tick1hz` and `ftest_512` are low. The first second after `rst` falls begins from a cleared state and is second 0 of the correction cycle. The trim word present during reset governs that second.
- R2: In an uncorrected second, exactly 100 `tick100` pulses are produced for 512 enables. The 100th pulse follows the 512th enable.
- R3: `trim_word[4:0]` is the magnitude N (0..31) and `trim_word[5]` is the sign. A 1 in the sign means speed up and a 0 means slow down. With N = 0, every second takes 512 enables, whatever the sign.
- R4: With the sign at 1, seconds 0..N-1 of each cycle of 8 x SECS_PER_MIN seconds (480 by default) take 511 enables. All other seconds take 512.
- R5: With the sign at 0, seconds 0..N-1 of each cycle of 16 x SECS_PER_MIN seconds (960 by default) take 513 enables. All other seconds take 512.
- R6: Each `tick100` pulse is high for the single clock cycle after the enable that caused it. Consecutive pulses, and the first pulse after reset or after a second boundary, are 5 or 6 enables apart.
- R7: `tick1hz` pulses exactly once per second, in the same cycle as the 100th `tick100` of that second.
- R8: A trim word change in the middle of a second has no effect on that second. The change takes effect from the next second. The seconds index then advances and wraps against the cycle length of the new sign.
- R9: `ftest_512` equals `tick512_en` delayed by one clock (low during reset). It does not depend on the trim word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick512_en | input | 1 | One-cycle enable per 512 Hz tick |
| trim_word | input | 6 | Bit 5 sign (1 = faster), bits 4..0 magnitude N |
| tick100 | output | 1 | One-cycle 100 Hz tick for the hundredths counter |
| tick1hz | output | 1 | One-cycle tick with the last 100 Hz tick of each second |
| ftest_512 | output | 1 | Uncorrected 512 Hz test output, one clock behind the enable |

## Verification
A corrupted accumulator shows up within one second as a second of the wrong length or as a 100 Hz gap outside 5..6 enables. A wrong in-second count makes `tick1hz` land on a pulse other than the 100th, and that is visible at the next second boundary. A wrong cycle index, or a trim word latched at the wrong moment, changes which seconds measure 511 or 513 enables. The bench therefore times every second in enables and compares it with the sign, N and the second's position in the cycle. It also runs through a full positive cycle and a full negative cycle so that the wrap point is exposed. Mid-second word changes and sparse enable patterns are exercised separately.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    localparam int TRIM_W = 6;
    localparam int MAG_W  = 5;

    typedef struct packed {
        logic             faster;
        logic [MAG_W-1:0] mag;
    } trim_word_t;

    typedef enum logic [1:0] {
        RATE_NOMINAL = 2'd0,
        RATE_FAST    = 2'd1,
        RATE_SLOW    = 2'd2
    } rate_e;

    // Rate for the current second given the active word and window membership.
    function automatic rate_e pick_rate(input trim_word_t w, input logic in_window);
        if (!in_window || w.mag == '0) begin
            return RATE_NOMINAL;
        end
        return w.faster ? RATE_FAST : RATE_SLOW;
    endfunction

    // Input ticks consumed by one second at the given rate.
    function automatic int rate_divisor(input rate_e r, input int base);
        case (r)
            RATE_FAST: return base - 1;
            RATE_SLOW: return base + 1;
            default:   return base;
        endcase
    endfunction

endpackage

// File: rtl/trim_word_latch.sv
module trim_word_latch
    import rtc_trim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  trim_word_t word_in,
    output trim_word_t word_q
);

    // The word is taken during reset and at each second boundary only.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            word_q <= word_in;
        end
    end

endmodule

// File: rtl/trim_cycle_tracker.sv
module trim_cycle_tracker
    import rtc_trim_pkg::*;
#(
    parameter int SECS_PER_MIN = 60,
    parameter int FAST_MINUTES = 8,
    parameter int SLOW_MINUTES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_end,
    input  trim_word_t cur_word,
    input  trim_word_t next_word,
    output rate_e      rate
);

    localparam int FAST_LEN = FAST_MINUTES * SECS_PER_MIN;
    localparam int SLOW_LEN = SLOW_MINUTES * SECS_PER_MIN;
    localparam int MAX_LEN  = (FAST_LEN > SLOW_LEN) ? FAST_LEN : SLOW_LEN;
    localparam int SEC_W    = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

    logic [SEC_W-1:0] sec_idx;
    logic [SEC_W-1:0] wrap_at;
    logic             in_window;

    // Wrap point follows the sign of the word that governs the coming second.
    assign wrap_at = next_word.faster ? SEC_W'(FAST_LEN - 1) : SEC_W'(SLOW_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_idx <= '0;
        end else if (sec_end) begin
            sec_idx <= (sec_idx >= wrap_at) ? '0 : sec_idx + 1'b1;
        end
    end

    assign in_window = int'(sec_idx) < int'(cur_word.mag);
    assign rate      = pick_rate(cur_word, in_window);

endmodule

// File: rtl/trim_frac_divider.sv
module trim_frac_divider
    import rtc_trim_pkg::*;
#(
    parameter int BASE_DIV      = 512,
    parameter int TICKS_PER_SEC = 100
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_en,
    input  rate_e rate,
    output logic  tick_out,
    output logic  sec_out,
    output logic  sec_end
);

    localparam int ACC_MAX = BASE_DIV + 1 + TICKS_PER_SEC;
    localparam int ACC_W   = $clog2(ACC_MAX + 1);
    localparam int CNT_W   = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] divisor;
    logic [CNT_W-1:0] cnt;
    logic             emit;
    logic             last_tick;

    assign divisor   = ACC_W'(rate_divisor(rate, BASE_DIV));
    assign acc_sum   = acc + ACC_W'(TICKS_PER_SEC);
    assign emit      = tick_en && (acc_sum >= divisor);
    assign last_tick = (cnt == CNT_W'(TICKS_PER_SEC - 1));
    assign sec_end   = emit && last_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            cnt      <= '0;
            tick_out <= 1'b0;
            sec_out  <= 1'b0;
        end else begin
            tick_out <= emit;
            sec_out  <= sec_end;
            if (sec_end) begin
                acc <= '0;
                cnt <= '0;
            end else if (emit) begin
                acc <= acc_sum - divisor;
                cnt <= cnt + 1'b1;
            end else if (tick_en) begin
                acc <= acc_sum;
            end
        end
    end

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int BASE_DIV      = 512,
    parameter int TICKS_PER_SEC = 100,
    parameter int SECS_PER_MIN  = 60,
    parameter int FAST_MINUTES  = 8,
    parameter int SLOW_MINUTES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick512_en,
    input  logic [TRIM_W-1:0] trim_word,
    output logic              tick100,
    output logic              tick1hz,
    output logic              ftest_512
);

    trim_word_t word_in;
    trim_word_t word_act;
    rate_e      rate;
    logic       sec_end;

    assign word_in = trim_word_t'(trim_word);

    // Test output is taken ahead of the corrected stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            ftest_512 <= 1'b0;
        end else begin
            ftest_512 <= tick512_en;
        end
    end

    trim_word_latch u_word (
        .clk     (clk),
        .rst     (rst),
        .load    (sec_end),
        .word_in (word_in),
        .word_q  (word_act)
    );

    trim_cycle_tracker #(
        .SECS_PER_MIN (SECS_PER_MIN),
        .FAST_MINUTES (FAST_MINUTES),
        .SLOW_MINUTES (SLOW_MINUTES)
    ) u_cycle (
        .clk       (clk),
        .rst       (rst),
        .sec_end   (sec_end),
        .cur_word  (word_act),
        .next_word (word_in),
        .rate      (rate)
    );

    trim_frac_divider #(
        .BASE_DIV      (BASE_DIV),
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick512_en),
        .rate     (rate),
        .tick_out (tick100),
        .sec_out  (tick1hz),
        .sec_end  (sec_end)
    );

endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
module rtc_trim_prescaler_chk (
    input logic clk,
    input logic rst,
    input logic tick512_en,
    input logic tick100,
    input logic tick1hz,
    input logic ftest_512
);

    logic [3:0]  gap_q;
    logic [7:0]  hund_q;
    logic [10:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            hund_q <= '0;
            len_q  <= '0;
        end else begin
            if (tick100) begin
                gap_q <= tick512_en ? 4'd1 : 4'd0;
            end else if (tick512_en) begin
                gap_q <= gap_q + 4'd1;
            end
            if (tick1hz) begin
                hund_q <= '0;
            end else if (tick100) begin
                hund_q <= hund_q + 8'd1;
            end
            if (tick1hz) begin
                len_q <= tick512_en ? 11'd1 : 11'd0;
            end else if (tick512_en) begin
                len_q <= len_q + 11'd1;
            end
        end
    end

    p_len_range_r2: assert property (@(posedge clk) disable iff (rst)
        tick1hz |-> (len_q >= 11'd511 && len_q <= 11'd513));

    p_tick_on_enable_r6: assert property (@(posedge clk) disable iff (rst)
        tick100 |-> $past(tick512_en));

    p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        tick100 |-> (gap_q == 4'd5 || gap_q == 4'd6));

    p_sec_with_tick_r7: assert property (@(posedge clk) disable iff (rst)
        tick1hz |-> tick100);

    p_hundredth_r7: assert property (@(posedge clk) disable iff (rst)
        tick1hz |-> hund_q == 8'd99);

    p_ftest_high_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(tick512_en) && !$past(rst)) |-> ftest_512);

    p_ftest_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(tick512_en) |-> !ftest_512);

endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick512_en (tick512_en),
    .tick100    (tick100),
    .tick1hz    (tick1hz),
    .ftest_512  (ftest_512)
);

// File: tb/rtc_trim_prescaler_bench.sv
module rtc_trim_prescaler_bench;

    localparam int SPM = 4;

    typedef struct packed {
        logic [5:0]  word;
        logic [15:0] nsec;
        logic [15:0] n_fast;
        logic [15:0] n_slow;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{6'b000000, 16'd5,  16'd0,  16'd0},
        '{6'b100000, 16'd5,  16'd0,  16'd0},
        '{6'b100011, 16'd40, 16'd6,  16'd0},
        '{6'b000010, 16'd70, 16'd0,  16'd4},
        '{6'b011111, 16'd40, 16'd0,  16'd31},
        '{6'b111111, 16'd34, 16'd33, 16'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick512_en = 1'b0;
    logic [5:0] trim_word = 6'd0;
    logic       tick100;
    logic       tick1hz;
    logic       ftest_512;

    int unsigned errors = 0;
    int unsigned checks = 0;
    int  en_cnt = 0;
    int  h_cnt = 0;
    int  gap = 0;
    int  last_len = 0;
    int  last_h = 0;
    bit  sec_done = 1'b0;
    logic prev_en = 1'b0;
    logic prev_rst = 1'b1;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    rtc_trim_prescaler #(.SECS_PER_MIN(SPM)) u_rtc_trim_prescaler (
        .clk        (clk),
        .rst        (rst),
        .tick512_en (tick512_en),
        .trim_word  (trim_word),
        .tick100    (tick100),
        .tick1hz    (tick1hz),
        .ftest_512  (ftest_512)
    );

    task automatic fail(input string tag, input int act, input int exp);
        errors++;
        $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) fail(tag, act, exp);
    endtask

    // Sample results of the previous edge, then drive the next inputs.
    task automatic step(input logic en, input logic r);
        @(negedge clk);
        check("R9 ftest", int'(ftest_512), int'(prev_en & ~prev_rst));
        if (tick100 === 1'b1) begin
            h_cnt++;
            if (!prev_rst) begin
                checks++;
                if (gap < 5 || gap > 6) fail("R6 gap", gap, 5);
            end
            gap = 0;
        end
        if (tick1hz === 1'b1) begin
            check("R7 with tick100", int'(tick100), 1);
            last_len = en_cnt;
            last_h   = h_cnt;
            en_cnt   = 0;
            h_cnt    = 0;
            sec_done = 1'b1;
        end
        prev_en    = en;
        prev_rst   = r;
        tick512_en = en;
        rst        = r;
        if (en && !r) begin
            en_cnt++;
            gap++;
        end
    endtask

    task automatic do_reset(input logic [5:0] w);
        trim_word = w;
        step(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b1);
            check("R1 tick100 in reset", int'(tick100), 0);
            check("R1 tick1hz in reset", int'(tick1hz), 0);
            check("R1 ftest in reset", int'(ftest_512), 0);
        end
        step(1'b0, 1'b0);
        en_cnt = 0;
        h_cnt  = 0;
        gap    = 0;
    endtask

    task automatic run_second(input int spacing, output int len, output int h);
        int n;
        n = 0;
        sec_done = 1'b0;
        while (!sec_done && n < 3000) begin
            step(1'b1, 1'b0);
            for (int k = 1; k < spacing; k++) step(1'b0, 1'b0);
            n++;
        end
        if (!sec_done) fail("R7 no second boundary", n, 513);
        len = last_len;
        h   = last_h;
    endtask

    function automatic int exp_div(input logic [5:0] w, input int s);
        int clen;
        clen = w[5] ? 8 * SPM : 16 * SPM;
        if (w[4:0] != 5'd0 && (s % clen) < int'(w[4:0])) return w[5] ? 511 : 513;
        return 512;
    endfunction

    initial begin
        int len, h, nf, ns;
        string tag;

        // Table walk: R1, R2, R3, R4, R5, R7
        for (int v = 0; v < NVEC; v++) begin
            do_reset(VECS[v].word);
            nf = 0;
            ns = 0;
            for (int s = 0; s < int'(VECS[v].nsec); s++) begin
                run_second(1, len, h);
                if (VECS[v].word[4:0] == 5'd0) tag = "R3 second length";
                else if (exp_div(VECS[v].word, s) == 512) tag = "R2 second length";
                else if (VECS[v].word[5]) tag = "R4 second length";
                else tag = "R5 second length";
                check(tag, len, exp_div(VECS[v].word, s));
                check("R7 ticks per second", h, 100);
                if (len == 511) nf++;
                if (len == 513) ns++;
            end
            check("R4 fast seconds", nf, int'(VECS[v].n_fast));
            check("R5 slow seconds", ns, int'(VECS[v].n_slow));
        end

        // Sparse enables, one in three cycles: R6, R4
        do_reset(6'b111111);
        for (int s = 0; s < 2; s++) begin
            run_second(3, len, h);
            check("R4 sparse length", len, 511);
            check("R6 sparse ticks", h, 100);
        end

        // Mid-second word changes: R8
        do_reset(6'b000000);
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0);
        trim_word = 6'b111111;
        run_second(1, len, h);
        check("R8 change held off", len, 512);
        run_second(1, len, h);
        check("R8 change applied", len, 511);
        for (int i = 0; i < 100; i++) step(1'b1, 1'b0);
        trim_word = 6'b000101;
        run_second(1, len, h);
        check("R8 sign change held off", len, 511);
        run_second(1, len, h);
        check("R8 sign change applied", len, 513);

        // Reset in the middle of a second: R1
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0);
        do_reset(6'b100001);
        run_second(1, len, h);
        check("R1 second 0 after reset", len, 511);
        check("R1 ticks after reset", h, 100);
        run_second(1, len, h);
        check("R1 second 1 after reset", len, 512);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", 190000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule